// File: doc/BRIEF.md
# Slot Hotplug Event and Eject Controller

This block sits between the slot hotplug logic of a bus bridge and the system control interrupt path. When a slot gains or loses a device, the block records the event in a pair of per-slot bitmaps. It raises a general-purpose event status bit, and it drives an interrupt request while that status bit and its enable bit are both set. System software reads the bitmaps, clears the status bit by writing a one to it, and can request removal of a slot by writing a bit pattern to the eject register. The block then emits a one-cycle eject strobe carrying the chosen slot number, but only for slots that can be hotplugged.

Each new event erases both bitmaps before it records its own slot, so the bitmaps always describe the single most recent event. A plug event that is flagged as a cold-boot insertion is ignored. The set of hotplug-capable slots is sampled from an input while reset is held. It is presented read-only as the removability register.

The eject path is a small state machine. In `EJ_IDLE` it waits for an eject write. A non-zero write latches the value and moves to `EJ_PICK`; a zero write stays in `EJ_IDLE`. In `EJ_PICK` it registers the lowest set bit as the slot number. It moves to `EJ_FIRE` if that slot is capable, or back to `EJ_IDLE` if it is not. `EJ_FIRE` drives the strobe for one cycle and returns to `EJ_IDLE`. Eject writes that arrive while the machine is outside `EJ_IDLE` are dropped.

Top module: `hp_hotplug_ctrl`

## Requirements
- R1: After reset the up and down bitmaps read 0, every event status and enable byte reads 0, `gpe_req` is 0 and `eject_stb` is 0.
- R2: The event block occupies byte addresses 0x00 to 0x03 and is accessed one byte at a time. Status is at 0x00 and 0x01, and bit n of byte k is status bit 8k+n. Enable is at 0x02 and 0x03, laid out the same way. Writes use `reg_wdata[7:0]`, and reads return the byte in `reg_rdata[7:0]` with the upper bits 0.
- R3: Status bits are write-one-to-clear, and writing 0 to a status bit leaves it unchanged. Enable bytes take the written value directly. When a hardware set and a software clear of the same status bit fall in the same cycle, the set wins.
- R4: A plug event (`ev_plug`=1, `ev_cold`=0) clears both bitmaps, sets bit `ev_slot` of the up bitmap and sets status bit 1. The new values are visible after the next clock edge.
- R5: An unplug event (`ev_unplug`=1 with no effective plug in the same cycle) clears both bitmaps, sets bit `ev_slot` of the down bitmap and sets status bit 1.
- R6: A plug event with `ev_cold`=1 changes neither bitmap nor the status bits.
- R7: `gpe_req` is 1 exactly while status bit 1 (address 0x00, bit 1) and enable bit 1 (address 0x02, bit 1) are both 1.
- R8: The up bitmap at 0x10 and the down bitmap at 0x14 are 32-bit read/write registers. An event in the same cycle as a write to either bitmap takes priority.
- R9: A non-zero write to the eject register at 0x18 selects the lowest set bit of the written value. If that slot is capable, exactly one cycle of `eject_stb` follows, with `eject_slot` equal to that slot. The strobe comes in the second cycle after the write edge. Higher set bits are never used.
- R10: No strobe is produced for a zero eject write, or when the lowest set bit names a slot whose capability bit is 0.
- R11: Reads of the eject register return 0.
- R12: The removability register at 0x1C reads the capability mask (bit s = 1 when slot s is capable) that was sampled from `slot_cap` during reset. Writes to it are ignored, and changes of `slot_cap` outside reset have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; samples `slot_cap` |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte address of the register access |
| reg_wdata | input | 32 | Write data (event block uses bits 7:0) |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| ev_plug | input | 1 | Slot insertion event pulse |
| ev_unplug | input | 1 | Slot removal event pulse |
| ev_cold | input | 1 | Marks a plug event as present at cold boot |
| ev_slot | input | 5 | Slot number of the event |
| slot_cap | input | 32 | Per-slot hotplug-capable mask, sampled in reset |
| gpe_req | output | 1 | Event interrupt request to the control interrupt logic |
| eject_stb | output | 1 | One-cycle eject strobe |
| eject_slot | output | 5 | Slot number qualified by `eject_stb` |

## Verification
The bench uses eject patterns with several bits set. The lowest set bit is sometimes capable and sometimes not, and a design that scans from the top or falls back to the next capable bit would strobe the wrong slot or strobe when it should stay quiet. It places a plug event after a bitmap already holding other bits, and a design that merges events instead of wiping would leave stale bits behind. It also drives an event and a bitmap write in the same cycle, a cold-boot plug while the enable bit is set, and a software clear of status. It changes the capability input after reset, and a design that tracks the live input rather than the sampled mask would change the removability readback or wrongly allow an eject.

// File: rtl/hp_pkg.sv
package hp_pkg;
    localparam int OFS_UP   = 'h10;
    localparam int OFS_DOWN = 'h14;
    localparam int OFS_EJ   = 'h18;
    localparam int OFS_RMV  = 'h1C;
    localparam int HP_STS_BIT = 1;

    typedef enum logic [1:0] {
        EJ_IDLE = 2'd0,
        EJ_PICK = 2'd1,
        EJ_FIRE = 2'd2
    } ej_state_t;
endpackage

// File: rtl/hp_gpe_regs.sv
module hp_gpe_regs #(
    parameter int GPE_LEN = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr,
    input  logic [$clog2(GPE_LEN)-1:0]   idx,
    input  logic [7:0]                   wbyte,
    input  logic                         hw_set,
    output logic [7:0]                   rbyte,
    output logic                         hp_sts,
    output logic                         req
);
    import hp_pkg::*;
    localparam int HALF  = GPE_LEN / 2;
    localparam int IDX_W = $clog2(GPE_LEN);

    logic [7:0] sts_q [HALF];
    logic [7:0] en_q  [HALF];
    logic [7:0] sts_d [HALF];
    logic [7:0] en_d  [HALF];
    logic [7:0] rd_sts [HALF];
    logic [7:0] rd_en  [HALF];

    genvar b;
    generate
        for (b = 0; b < HALF; b++) begin : g_byte
            logic hit_s;
            logic hit_e;
            logic [7:0] set_mask;
            assign hit_s    = wr && (idx == IDX_W'(b));
            assign hit_e    = wr && (idx == IDX_W'(b + HALF));
            assign set_mask = ((b == HP_STS_BIT / 8) && hw_set) ? 8'(1 << (HP_STS_BIT % 8)) : 8'h00;
            assign sts_d[b] = (hit_s ? (sts_q[b] & ~wbyte) : sts_q[b]) | set_mask;
            assign en_d[b]  = hit_e ? wbyte : en_q[b];
            assign rd_sts[b] = (idx == IDX_W'(b)) ? sts_q[b] : 8'h00;
            assign rd_en[b]  = (idx == IDX_W'(b + HALF)) ? en_q[b] : 8'h00;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < HALF; i++) begin
                sts_q[i] <= 8'h00;
                en_q[i]  <= 8'h00;
            end
        end else begin
            sts_q <= sts_d;
            en_q  <= en_d;
        end
    end

    always_comb begin
        rbyte = 8'h00;
        for (int i = 0; i < HALF; i++) begin
            rbyte = rbyte | rd_sts[i] | rd_en[i];
        end
    end

    assign hp_sts = sts_q[HP_STS_BIT / 8][HP_STS_BIT % 8];
    assign req    = hp_sts & en_q[HP_STS_BIT / 8][HP_STS_BIT % 8];
endmodule

// File: rtl/hp_slot_maps.sv
module hp_slot_maps #(
    parameter int SLOTS = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_up,
    input  logic                       wr_down,
    input  logic [SLOTS-1:0]           wdata,
    input  logic                       plug,
    input  logic                       unplug,
    input  logic [$clog2(SLOTS)-1:0]   slot,
    output logic [SLOTS-1:0]           up_q,
    output logic [SLOTS-1:0]           down_q
);
    logic [SLOTS-1:0] onehot;
    logic             any_ev;

    assign onehot = SLOTS'(1) << slot;
    assign any_ev = plug | unplug;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_q   <= '0;
            down_q <= '0;
        end else if (any_ev) begin
            up_q   <= plug   ? onehot : '0;
            down_q <= unplug ? onehot : '0;
        end else begin
            if (wr_up)   up_q   <= wdata;
            if (wr_down) down_q <= wdata;
        end
    end
endmodule

// File: rtl/hp_eject_fsm.sv
module hp_eject_fsm #(
    parameter int SLOTS = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_ej,
    input  logic [SLOTS-1:0]           wdata,
    input  logic [SLOTS-1:0]           cap_mask,
    output logic                       stb,
    output logic [$clog2(SLOTS)-1:0]   slot
);
    import hp_pkg::*;
    localparam int SLOT_W = $clog2(SLOTS);

    ej_state_t         state_q;
    ej_state_t         state_d;
    logic [SLOTS-1:0]  val_q;
    logic [SLOT_W-1:0] slot_q;
    logic [SLOT_W-1:0] low_idx;

    function automatic logic [SLOT_W-1:0] lowest_set(input logic [SLOTS-1:0] v);
        logic [SLOT_W-1:0] r;
        r = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (v[i]) r = SLOT_W'(i);
        end
        return r;
    endfunction

    assign low_idx = lowest_set(val_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EJ_IDLE: if (wr_ej && (wdata != '0)) state_d = EJ_PICK;
            EJ_PICK: state_d = cap_mask[low_idx] ? EJ_FIRE : EJ_IDLE;
            EJ_FIRE: state_d = EJ_IDLE;
            default: state_d = EJ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= EJ_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q  <= '0;
            slot_q <= '0;
        end else begin
            if (state_q == EJ_IDLE && wr_ej) val_q <= wdata;
            if (state_q == EJ_PICK)          slot_q <= low_idx;
        end
    end

    always_comb begin
        stb  = 1'b0;
        slot = slot_q;
        unique case (state_q)
            EJ_IDLE: stb = 1'b0;
            EJ_PICK: stb = 1'b0;
            EJ_FIRE: stb = 1'b1;
            default: stb = 1'b0;
        endcase
    end
endmodule

// File: rtl/hp_hotplug_ctrl.sv
module hp_hotplug_ctrl #(
    parameter int SLOTS   = 32,
    parameter int ADDR_W  = 5,
    parameter int GPE_LEN = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_wr,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic [SLOTS-1:0]           reg_wdata,
    output logic [SLOTS-1:0]           reg_rdata,
    input  logic                       ev_plug,
    input  logic                       ev_unplug,
    input  logic                       ev_cold,
    input  logic [$clog2(SLOTS)-1:0]   ev_slot,
    input  logic [SLOTS-1:0]           slot_cap,
    output logic                       gpe_req,
    output logic                       eject_stb,
    output logic [$clog2(SLOTS)-1:0]   eject_slot
);
    import hp_pkg::*;
    localparam int IDX_W = $clog2(GPE_LEN);

    logic             in_gpe;
    logic             sel_up, sel_down, sel_ej, sel_rmv;
    logic             plug_eff, unplug_eff;
    logic [7:0]       gpe_rbyte;
    logic             gpe_hp_sts;
    logic [SLOTS-1:0] up_q, down_q, rmv_q;

    assign in_gpe   = (reg_addr < ADDR_W'(GPE_LEN));
    assign sel_up   = (reg_addr == ADDR_W'(OFS_UP));
    assign sel_down = (reg_addr == ADDR_W'(OFS_DOWN));
    assign sel_ej   = (reg_addr == ADDR_W'(OFS_EJ));
    assign sel_rmv  = (reg_addr == ADDR_W'(OFS_RMV));

    assign plug_eff   = ev_plug & ~ev_cold;
    assign unplug_eff = ev_unplug & ~plug_eff;

    always_ff @(posedge clk) begin
        if (!rst_n) rmv_q <= slot_cap;
    end

    hp_gpe_regs #(.GPE_LEN(GPE_LEN)) u_gpe (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (reg_wr && in_gpe),
        .idx    (reg_addr[IDX_W-1:0]),
        .wbyte  (reg_wdata[7:0]),
        .hw_set (plug_eff | unplug_eff),
        .rbyte  (gpe_rbyte),
        .hp_sts (gpe_hp_sts),
        .req    (gpe_req)
    );

    hp_slot_maps #(.SLOTS(SLOTS)) u_maps (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_up   (reg_wr && sel_up),
        .wr_down (reg_wr && sel_down),
        .wdata   (reg_wdata),
        .plug    (plug_eff),
        .unplug  (unplug_eff),
        .slot    (ev_slot),
        .up_q    (up_q),
        .down_q  (down_q)
    );

    hp_eject_fsm #(.SLOTS(SLOTS)) u_ej (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ej    (reg_wr && sel_ej),
        .wdata    (reg_wdata),
        .cap_mask (rmv_q),
        .stb      (eject_stb),
        .slot     (eject_slot)
    );

    always_comb begin
        reg_rdata = '0;
        if (in_gpe)        reg_rdata = SLOTS'(gpe_rbyte);
        else if (sel_up)   reg_rdata = up_q;
        else if (sel_down) reg_rdata = down_q;
        else if (sel_rmv)  reg_rdata = rmv_q;
    end
endmodule

// File: rtl/hp_hotplug_chk.sv
module hp_hotplug_chk #(
    parameter int SLOTS = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       ev_plug,
    input logic                       ev_unplug,
    input logic                       ev_cold,
    input logic [$clog2(SLOTS)-1:0]   ev_slot,
    input logic                       reg_wr,
    input logic [SLOTS-1:0]           up_q,
    input logic [SLOTS-1:0]           down_q,
    input logic [SLOTS-1:0]           rmv_q,
    input logic                       gpe_hp_sts,
    input logic                       eject_stb,
    input logic [$clog2(SLOTS)-1:0]   eject_slot
);
    // R4
    plug_sets_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_plug && !ev_cold) |=> (up_q == (SLOTS'(1) << $past(ev_slot))) && (down_q == '0));

    // R5
    unplug_sets_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_unplug && !(ev_plug && !ev_cold)) |=> (down_q == (SLOTS'(1) << $past(ev_slot))) && (up_q == '0));

    // R4
    event_raises_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_plug && !ev_cold) || ev_unplug) |=> gpe_hp_sts);

    // R6
    cold_plug_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_plug && ev_cold && !ev_unplug && !reg_wr) |=> ($stable(up_q) && $stable(down_q)));

    // R9
    eject_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eject_stb |=> !eject_stb);

    // R10
    eject_capable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eject_stb |-> rmv_q[eject_slot]);

    // R12
    rmv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(rmv_q));
endmodule

bind hp_hotplug_ctrl hp_hotplug_chk #(.SLOTS(SLOTS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_plug    (ev_plug),
    .ev_unplug  (ev_unplug),
    .ev_cold    (ev_cold),
    .ev_slot    (ev_slot),
    .reg_wr     (reg_wr),
    .up_q       (up_q),
    .down_q     (down_q),
    .rmv_q      (rmv_q),
    .gpe_hp_sts (gpe_hp_sts),
    .eject_stb  (eject_stb),
    .eject_slot (eject_slot)
);

// File: tb/sim_hp_hotplug_ctrl.sv
`timescale 1ns/1ps
module sim_hp_hotplug_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ev_plug = 1'b0, ev_unplug = 1'b0, ev_cold = 1'b0;
    logic [4:0]  ev_slot = '0;
    logic [31:0] slot_cap = ~32'h0000_0050;
    logic        gpe_req, eject_stb;
    logic [4:0]  eject_slot;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    hp_hotplug_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_plug(ev_plug),
        .ev_unplug(ev_unplug), .ev_cold(ev_cold), .ev_slot(ev_slot),
        .slot_cap(slot_cap), .gpe_req(gpe_req), .eject_stb(eject_stb),
        .eject_slot(eject_slot)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic event_pulse(input logic p, input logic u, input logic c, input logic [4:0] s);
        ev_plug = p; ev_unplug = u; ev_cold = c; ev_slot = s;
        @(negedge clk);
        ev_plug = 1'b0; ev_unplug = 1'b0; ev_cold = 1'b0;
    endtask

    task automatic eject_try(input logic [31:0] v, output int cnt, output logic [4:0] s);
        cnt = 0; s = '0;
        wr(5'h18, v);
        for (int i = 0; i < 5; i++) begin
            if (eject_stb) begin cnt++; s = eject_slot; end
            @(negedge clk);
        end
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        rd(5'h10, d); check("R1 up", d, 0);
        rd(5'h14, d); check("R1 down", d, 0);
        for (int a = 0; a < 4; a++) begin
            rd(5'(a), d); check("R1 gpe byte", d, 0);
        end
        check("R1 gpe_req", 32'(gpe_req), 0);
        check("R1 eject_stb", 32'(eject_stb), 0);
    endtask

    task automatic t_gpe_bytes();
        logic [31:0] d;
        wr(5'h03, 32'hFFFF_FFC3);
        rd(5'h03, d); check("R2 enable byte3", d, 32'h0000_00C3);
        wr(5'h01, 32'h0000_00FF);
        rd(5'h01, d); check("R3 status unchanged", d, 0);
        wr(5'h03, 32'h0);
        rd(5'h03, d); check("R3 enable plain write", d, 0);
    endtask

    task automatic t_plug_unplug();
        logic [31:0] d;
        wr(5'h10, 32'hA5A5_0000);
        rd(5'h10, d); check("R8 up rw", d, 32'hA5A5_0000);
        wr(5'h14, 32'h0000_5A5A);
        rd(5'h14, d); check("R8 down rw", d, 32'h0000_5A5A);
        event_pulse(1, 0, 0, 5'd7);
        rd(5'h10, d); check("R4 up after plug", d, 32'h0000_0080);
        rd(5'h14, d); check("R4 down wiped", d, 0);
        rd(5'h00, d); check("R4 status bit1", d, 32'h02);
        event_pulse(0, 1, 0, 5'd3);
        rd(5'h10, d); check("R5 up wiped", d, 0);
        rd(5'h14, d); check("R5 down after unplug", d, 32'h0000_0008);
        rd(5'h00, d); check("R5 status bit1", d, 32'h02);
    endtask

    task automatic t_gpe_req();
        logic [31:0] d;
        check("R7 req no enable", 32'(gpe_req), 0);
        wr(5'h02, 32'h02);
        check("R7 req asserted", 32'(gpe_req), 1);
        wr(5'h00, 32'h02);
        rd(5'h00, d); check("R3 w1c status", d, 0);
        check("R7 req after clear", 32'(gpe_req), 0);
    endtask

    task automatic t_cold();
        logic [31:0] d;
        event_pulse(1, 0, 0, 5'd0);
        wr(5'h00, 32'h02);
        event_pulse(1, 0, 1, 5'd9);
        rd(5'h10, d); check("R6 up kept", d, 32'h1);
        rd(5'h14, d); check("R6 down kept", d, 0);
        rd(5'h00, d); check("R6 status quiet", d, 0);
        check("R6 no req", 32'(gpe_req), 0);
    endtask

    task automatic t_priority();
        logic [31:0] d;
        reg_wr = 1'b1; reg_addr = 5'h10; reg_wdata = 32'h0000_FFFF;
        ev_plug = 1'b1; ev_cold = 1'b0; ev_slot = 5'd2;
        @(negedge clk);
        reg_wr = 1'b0; ev_plug = 1'b0; reg_wdata = '0;
        rd(5'h10, d); check("R8 event beats write", d, 32'h4);
        wr(5'h00, 32'h02);
        reg_wr = 1'b1; reg_addr = 5'h00; reg_wdata = 32'h02;
        ev_unplug = 1'b1; ev_slot = 5'd1;
        @(negedge clk);
        reg_wr = 1'b0; ev_unplug = 1'b0; reg_wdata = '0;
        rd(5'h00, d); check("R3 set beats clear", d, 32'h02);
        wr(5'h00, 32'h02);
        wr(5'h02, 32'h00);
    endtask

    task automatic t_eject();
        int c; logic [4:0] s; logic [31:0] d;
        eject_try(32'h0000_0400, c, s);
        check("R9 strobe count slot10", 32'(c), 1);
        check("R9 slot10", 32'(s), 10);
        eject_try(32'h8000_0000, c, s);
        check("R9 slot31", 32'(s), 31);
        check("R9 count slot31", 32'(c), 1);
        eject_try(32'h0000_0060, c, s);
        check("R9 lowest bit slot5", 32'(s), 5);
        check("R9 count slot5", 32'(c), 1);
        eject_try(32'h0000_0050, c, s);
        check("R10 non-capable lowest", 32'(c), 0);
        eject_try(32'h0, c, s);
        check("R10 zero write", 32'(c), 0);
        rd(5'h18, d); check("R11 eject reads zero", d, 0);
    endtask

    task automatic t_rmv();
        logic [31:0] d;
        rd(5'h1C, d); check("R12 rmv mask", d, 32'hFFFF_FFAF);
        wr(5'h1C, 32'h0);
        rd(5'h1C, d); check("R12 rmv write ignored", d, 32'hFFFF_FFAF);
        slot_cap = 32'h0000_FFFF;
        @(negedge clk);
        rd(5'h1C, d); check("R12 live input ignored", d, 32'hFFFF_FFAF);
        do_reset();
        rd(5'h1C, d); check("R12 resampled at reset", d, 32'h0000_FFFF);
        rd(5'h10, d); check("R1 up after reset", d, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        t_reset_state();
        t_gpe_bytes();
        t_plug_unplug();
        t_gpe_req();
        t_cold();
        t_priority();
        t_eject();
        t_rmv();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule